// File: doc/BRIEF.md
# Dual-Channel Serial ADC Frame Controller

This block sits on the host side of a dual-converter, 16-bit sampling ADC that returns results serially. It runs the conversion handshake. It drops the active-low chip select, then raises one combined start/read strobe and waits for the converter's busy line. It then generates 20 conversion-clock cycles from the system clock and shifts in a 20-bit frame from each of two serial data lanes (A and B). It checks that the conversion ends, and hands the captured samples to the system through a valid/ready port.

Each frame carries a channel flag, then a converter flag, then the 16-bit two's-complement sample (MSB first), and ends in two zero bits. A 2-bit mode input tells the controller three things: where the channel number comes from (the address pin or the frame's own flag), whether both lanes carry a sample, and how each sample is tagged. The channel-address output is loaded once at the start of a frame and is held until chip select rises again. Its setup and hold around the first falling clock edge are therefore many system cycles long.

The state machine has seven states. IDLE goes to SELECT when `run` is high, which latches the address and the mode. SELECT goes to STROBE after one cycle. STROBE goes to SHIFT when the synchronised busy line is high, or back to IDLE on a rise timeout. SHIFT goes to DRAIN after the 20th falling clock edge. DRAIN goes to OUT_A when busy is low, or to IDLE on a tail timeout. OUT_A goes to IDLE when the sample is accepted in a single-lane mode, or to OUT_B in a dual-lane mode. OUT_B goes to IDLE when its sample is accepted.

Top module: `adc_frame_ctrl`

## Requirements
- R1: After reset, cs_n=1, cnv_rd=0, sclk=0, m_valid=0, frame_err=0 and timeout_err=0.
- R2: cnv_rd is high only while cs_n is low. cs_n falls at least one system cycle before cnv_rd rises. cnv_rd stays high until busy is seen high.
- R3: Each frame produces exactly 20 rising edges of sclk. sclk is low whenever the controller is not shifting.
- R4: At frame start, addr_o takes the value of addr_sel and holds it while cs_n stays low. Changing addr_sel during a frame does not affect addr_o.
- R5: Bits are captured on sclk falling edges. Frame bit 1 is the channel flag, bit 2 is the converter flag, bits 3..18 are the sample MSB first, and bits 19..20 are the trailing bits. m_data is bits 3..18 unchanged (two's complement, 0x8000 to 0x7FFF).
- R6: Mode 2'b00 delivers two samples per frame, lane A first. Both carry m_chan = latched address; m_conv is 0 for lane A and 1 for lane B.
- R7: Mode 2'b01 delivers one sample from lane A, with m_chan = latched address and m_conv = frame bit 2. Lane B is ignored.
- R8: Mode 2'b10 delivers two samples, lane A first. m_chan is frame bit 1 of that lane's frame; m_conv is 0 for lane A and 1 for lane B.
- R9: Mode 2'b11 delivers one sample from lane A, with m_chan = frame bit 1 and m_conv = frame bit 2.
- R10: While m_valid is high and m_ready is low, m_valid, m_data, m_chan and m_conv hold. No new frame starts before the last sample of the current frame is accepted.
- R11: If the trailing bits of a lane that is used are nonzero, frame_err is set and stays set until reset, and the sample is still delivered. Trailing bits on an ignored lane have no effect.
- R12: If busy is not high within BUSY_RISE_MAX cycles of cnv_rd rising, timeout_err is set (sticky), cs_n returns high and no sample is delivered.
- R13: If busy is still high BUSY_TAIL cycles after the 20th clock, timeout_err is set, cs_n returns high and no sample is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Start a conversion when idle |
| mode | input | 2 | Frame decoding mode, latched per frame |
| addr_sel | input | 1 | Requested channel (0 or 1) for address modes |
| busy | input | 1 | Converter busy, asynchronous |
| sdo_a | input | 1 | Serial data lane A, asynchronous |
| sdo_b | input | 1 | Serial data lane B, asynchronous |
| m_ready | input | 1 | Sample sink ready |
| cs_n | output | 1 | Active-low chip select |
| cnv_rd | output | 1 | Combined convert-start / read strobe |
| sclk | output | 1 | Conversion clock |
| addr_o | output | 1 | Channel-address pin |
| m_valid | output | 1 | Sample valid |
| m_data | output | 16 | Two's-complement sample |
| m_chan | output | 1 | Channel tag (0 or 1) |
| m_conv | output | 1 | Converter tag (0 = A, 1 = B) |
| frame_err | output | 1 | Sticky trailing-bit error |
| timeout_err | output | 1 | Sticky busy timeout |

## Verification
The bench builds the controller with DIV_HALF=3, the smallest half-period that still lets the two-stage synchronisers settle before each falling edge. At this setting a frame takes about 120 cycles, so dozens of random frames in all four modes fit in a short run. BUSY_RISE_MAX=8 and BUSY_TAIL=8 leave only a few cycles of slack over the converter model's own busy latency. A converter that never raises busy, or one whose busy sticks high, therefore reaches both timeout paths within a handful of cycles.

// File: rtl/adc_fc_pkg.sv
package adc_fc_pkg;

    localparam int FRAME_BITS = 20;
    localparam int SAMPLE_W   = 16;
    localparam int LANES      = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SELECT,
        ST_STROBE,
        ST_SHIFT,
        ST_DRAIN,
        ST_OUT_A,
        ST_OUT_B
    } fc_state_e;

    // mode bit 1: channel from frame flag; mode bit 0: single lane, tag from frame
    function automatic logic mode_single_lane(input logic [1:0] m);
        return m[0];
    endfunction

    function automatic logic mode_auto_channel(input logic [1:0] m);
        return m[1];
    endfunction

endpackage

// File: rtl/adc_fc_sclk_gen.sv
module adc_fc_sclk_gen #(
    parameter int DIV_HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic sclk_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap   = en && (cnt == CW'(DIV_HALF - 1));
    assign rise_o = wrap && !sclk_o;
    assign fall_o = wrap && sclk_o;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            sclk_o <= 1'b0;
        end else if (!en) begin
            cnt    <= '0;
            sclk_o <= 1'b0;
        end else if (wrap) begin
            cnt    <= '0;
            sclk_o <= ~sclk_o;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R3: clock parks low once the enable drops
    a_r3_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !sclk_o);

    // R3: clock only starts toggling while enabled
    a_r3_rise_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |-> $past(en));

endmodule

// File: rtl/adc_fc_sync.sv
module adc_fc_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] pipe;

    always_ff @(posedge clk) begin
        if (!rst_n) pipe[0] <= '0;
        else        pipe[0] <= d_i;
    end

    genvar s;
    generate
        for (s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[s] <= '0;
                else        pipe[s] <= pipe[s-1];
            end
        end
    endgenerate

    assign q_o = pipe[STAGES-1];

endmodule

// File: rtl/adc_fc_deser.sv
module adc_fc_deser #(
    parameter int LANES = 2,
    parameter int BITS  = 20
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       shift_i,
    input  logic [LANES-1:0]           din_i,
    output logic [LANES-1:0][BITS-1:0] frame_o
);
    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            logic [BITS-1:0] sh;
            always_ff @(posedge clk) begin
                if (!rst_n)       sh <= '0;
                else if (shift_i) sh <= {sh[BITS-2:0], din_i[g]};
            end
            assign frame_o[g] = sh;
        end
    endgenerate

endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
    import adc_fc_pkg::*;
#(
    parameter int DIV_HALF      = 4,
    parameter int BUSY_RISE_MAX = 16,
    parameter int BUSY_TAIL     = 32,
    parameter int SYNC_STAGES   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic [1:0]          mode,
    input  logic                addr_sel,
    input  logic                busy,
    input  logic                sdo_a,
    input  logic                sdo_b,
    input  logic                m_ready,
    output logic                cs_n,
    output logic                cnv_rd,
    output logic                sclk,
    output logic                addr_o,
    output logic                m_valid,
    output logic [SAMPLE_W-1:0] m_data,
    output logic                m_chan,
    output logic                m_conv,
    output logic                frame_err,
    output logic                timeout_err
);
    localparam int TMO_MAX = (BUSY_RISE_MAX > BUSY_TAIL) ? BUSY_RISE_MAX : BUSY_TAIL;
    localparam int TMO_W   = $clog2(TMO_MAX + 1);
    localparam int BCW     = $clog2(FRAME_BITS);
    localparam int DATA_HI = FRAME_BITS - 3;

    fc_state_e state, nxt;

    logic                             busy_s;
    logic [LANES-1:0]                 sdo_s;
    logic [LANES-1:0][FRAME_BITS-1:0] frames;
    logic                             sclk_en, sclk_rise, sclk_fall;
    logic [BCW-1:0]                   fall_cnt;
    logic [TMO_W-1:0]                 tmo_cnt;
    logic                             tmo_hit, shift_done, lane_b;
    logic [1:0]                       mode_q;
    logic [FRAME_BITS-1:0]            cur_frame;

    adc_fc_sync #(.W(1), .STAGES(SYNC_STAGES)) u_busy_sync (
        .clk(clk), .rst_n(rst_n), .d_i(busy), .q_o(busy_s));

    adc_fc_sync #(.W(LANES), .STAGES(SYNC_STAGES)) u_sdo_sync (
        .clk(clk), .rst_n(rst_n), .d_i({sdo_b, sdo_a}), .q_o(sdo_s));

    adc_fc_sclk_gen #(.DIV_HALF(DIV_HALF)) u_sclk (
        .clk(clk), .rst_n(rst_n), .en(sclk_en),
        .sclk_o(sclk), .rise_o(sclk_rise), .fall_o(sclk_fall));

    adc_fc_deser #(.LANES(LANES), .BITS(FRAME_BITS)) u_deser (
        .clk(clk), .rst_n(rst_n), .shift_i(sclk_fall && (state == ST_SHIFT)),
        .din_i(sdo_s), .frame_o(frames));

    assign shift_done = (state == ST_SHIFT) && sclk_fall && (fall_cnt == BCW'(FRAME_BITS - 1));
    assign tmo_hit    = ((state == ST_STROBE) && !busy_s && (tmo_cnt == TMO_W'(BUSY_RISE_MAX - 1)))
                     || ((state == ST_DRAIN) && busy_s && (tmo_cnt == TMO_W'(BUSY_TAIL - 1)));

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (run)        nxt = ST_SELECT;
            ST_SELECT:                 nxt = ST_STROBE;
            ST_STROBE: if (busy_s)     nxt = ST_SHIFT;
                       else if (tmo_hit) nxt = ST_IDLE;
            ST_SHIFT:  if (shift_done) nxt = ST_DRAIN;
            ST_DRAIN:  if (!busy_s)    nxt = ST_OUT_A;
                       else if (tmo_hit) nxt = ST_IDLE;
            ST_OUT_A:  if (m_ready)    nxt = mode_single_lane(mode_q) ? ST_IDLE : ST_OUT_B;
            ST_OUT_B:  if (m_ready)    nxt = ST_IDLE;
            default:                   nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // outputs
    always_comb begin
        cs_n      = 1'b1;
        cnv_rd    = 1'b0;
        sclk_en   = 1'b0;
        m_valid   = 1'b0;
        lane_b    = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_SELECT: cs_n = 1'b0;
            ST_STROBE: begin cs_n = 1'b0; cnv_rd = 1'b1; end
            ST_SHIFT:  begin cs_n = 1'b0; sclk_en = 1'b1; end
            ST_DRAIN:  cs_n = 1'b0;
            ST_OUT_A:  m_valid = 1'b1;
            ST_OUT_B:  begin m_valid = 1'b1; lane_b = 1'b1; end
            default:   ;
        endcase
        cur_frame = frames[lane_b];
        m_data    = cur_frame[DATA_HI -: SAMPLE_W];
        m_chan    = mode_auto_channel(mode_q) ? cur_frame[FRAME_BITS-1] : addr_o;
        m_conv    = mode_single_lane(mode_q) ? frames[0][FRAME_BITS-2] : lane_b;
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q      <= 2'b00;
            addr_o      <= 1'b0;
            fall_cnt    <= '0;
            tmo_cnt     <= '0;
            frame_err   <= 1'b0;
            timeout_err <= 1'b0;
        end else begin
            if (state == ST_IDLE && run) begin
                mode_q <= mode;
                addr_o <= addr_sel;
            end
            if (state != ST_SHIFT)  fall_cnt <= '0;
            else if (sclk_fall)     fall_cnt <= fall_cnt + 1'b1;
            if (state != nxt)                        tmo_cnt <= '0;
            else if (tmo_cnt != TMO_W'(TMO_MAX))     tmo_cnt <= tmo_cnt + 1'b1;
            if (tmo_hit) timeout_err <= 1'b1;
            if (state == ST_DRAIN && !busy_s) begin
                if (frames[0][1:0] != 2'b00 ||
                    (!mode_single_lane(mode_q) && frames[1][1:0] != 2'b00))
                    frame_err <= 1'b1;
            end
        end
    end

    // R2: strobe only under an asserted chip select
    a_r2_strobe_under_cs: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_rd |-> !cs_n);

    // R2: chip select leads the strobe by at least one cycle
    a_r2_cs_leads: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnv_rd) |-> $past(!cs_n));

    // R3: the conversion clock is high only while shifting
    a_r3_sclk_in_shift: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> (state == ST_SHIFT));

    // R4: address pin frozen while chip select stays low
    a_r4_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n)) |-> $stable(addr_o));

    // R10: a stalled sample holds
    a_r10_valid_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_chan) && $stable(m_conv)));

    // R11: framing error is sticky
    a_r11_ferr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> frame_err);

    // R12: a timeout leaves the converter deselected
    a_r12_tmo_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err) |-> (cs_n && !m_valid));

endmodule

// File: tb/test_adc_frame_ctrl.sv
module test_adc_frame_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic        addr_sel = 1'b0;
    logic        busy;
    logic        sdo_a, sdo_b;
    logic        m_ready = 1'b0;
    logic        cs_n, cnv_rd, sclk, addr_o, m_valid, m_chan, m_conv, frame_err, timeout_err;
    logic [15:0] m_data;

    int checks = 0;
    int fails  = 0;

    logic [19:0] fa = '0, fb = '0;
    int          fault = 0;     // 0 normal, 1 busy never rises, 2 busy stuck high
    int          rise_cnt = 0;
    logic        seen_addr = 1'b0;
    logic        cs_at_strobe = 1'b1;
    logic        exp_ferr = 1'b0;

    always #5 clk = ~clk;

    adc_frame_ctrl #(.DIV_HALF(3), .BUSY_RISE_MAX(8), .BUSY_TAIL(8), .SYNC_STAGES(2)) i_adc_frame_ctrl (
        .clk(clk), .rst_n(rst_n), .run(run), .mode(mode), .addr_sel(addr_sel),
        .busy(busy), .sdo_a(sdo_a), .sdo_b(sdo_b), .m_ready(m_ready),
        .cs_n(cs_n), .cnv_rd(cnv_rd), .sclk(sclk), .addr_o(addr_o),
        .m_valid(m_valid), .m_data(m_data), .m_chan(m_chan), .m_conv(m_conv),
        .frame_err(frame_err), .timeout_err(timeout_err));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // converter model
    initial begin
        busy = 1'b0; sdo_a = 1'b0; sdo_b = 1'b0;
        forever begin
            @(posedge cnv_rd);
            cs_at_strobe = cs_n;
            if (fault != 1) begin
                repeat (2) @(posedge clk);
                #1 busy = 1'b1;
                for (int k = 0; k < 20; k++) begin
                    @(posedge sclk);
                    #1;
                    sdo_a = fa[19-k];
                    sdo_b = fb[19-k];
                    @(negedge sclk);
                    if (k == 0) seen_addr = addr_o;
                end
                if (fault == 0) begin
                    repeat (2) @(posedge clk);
                    #1 busy = 1'b0;
                end else begin
                    @(negedge rst_n);
                    busy = 1'b0;
                end
            end
        end
    end

    initial forever begin
        @(posedge sclk);
        rise_cnt++;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R10 watchdog: actual=hung expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    function automatic logic [17:0] exp_word(input logic [1:0] md, input logic ad,
                                             input logic [19:0] a, input logic [19:0] b, input int idx);
        logic [19:0] f;
        f = (idx == 0) ? a : b;
        return {(md[1] ? f[19] : ad), (md[0] ? a[18] : (idx != 0)), f[17:2]};
    endfunction

    function automatic string mode_req(input logic [1:0] md);
        case (md)
            2'b00:   return "R6";
            2'b01:   return "R7";
            2'b10:   return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; run = 1'b0; m_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_ferr = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_frame(input logic [1:0] md, input logic ad, input logic [19:0] a, input logic [19:0] b);
        int r0, got, guard, nexp;
        logic [17:0] act;
        @(negedge clk);
        mode = md; addr_sel = ad; fa = a; fb = b; fault = 0;
        r0 = rise_cnt;
        run = 1'b1;
        while (cs_n) @(negedge clk);
        run = 1'b0;
        addr_sel = ~ad;                 // R4: change mid-frame, must not matter
        nexp = md[0] ? 1 : 2;
        got = 0; guard = 0;
        while (got < nexp && guard < 3000) begin
            @(negedge clk);
            guard++;
            m_ready = ($urandom % 3) != 0;
            if (m_valid && m_ready) begin
                act = {m_chan, m_conv, m_data};
                chk({mode_req(md), "/R5 sample"}, 32'(act), 32'(exp_word(md, ad, a, b, got)));
                got++;
            end
        end
        @(negedge clk);
        m_ready = 1'b0;
        exp_ferr = exp_ferr | (a[1:0] != 2'b00) | (!md[0] && b[1:0] != 2'b00);
        chk({mode_req(md), "/R10 sample count"}, 32'(got), 32'(nexp));
        chk("R3 sclk rises", 32'(rise_cnt - r0), 32'd20);
        chk("R4 addr at first fall", 32'(seen_addr), 32'(ad));
        chk("R2 cs low at strobe", 32'(cs_at_strobe), 32'd0);
        chk("R11 frame_err", 32'(frame_err), 32'(exp_ferr));
        chk("R3 sclk idle", 32'(sclk), 32'd0);
    endtask

    function automatic logic [19:0] rand_frame(input logic [1:0] md, input logic lane_b, input logic s1);
        logic s2;
        s2 = (md[0] && !lane_b) ? 1'($urandom) : 1'b0;
        return {(md[1] ? s1 : 1'b0), s2, 16'($urandom), 2'b00};
    endfunction

    task automatic do_timeout(input int flt, input string req);
        logic saw_valid;
        @(negedge clk);
        mode = 2'b00; fa = '0; fb = '0; fault = flt;
        run = 1'b1;
        while (cs_n) @(negedge clk);
        run = 1'b0; m_ready = 1'b1;
        saw_valid = 1'b0;
        for (int i = 0; i < 400 && !timeout_err; i++) begin
            @(negedge clk);
            if (m_valid) saw_valid = 1'b1;
        end
        repeat (4) begin
            @(negedge clk);
            if (m_valid) saw_valid = 1'b1;
        end
        chk({req, " timeout_err"}, 32'(timeout_err), 32'd1);
        chk({req, " cs_n released"}, 32'(cs_n), 32'd1);
        chk({req, " no strobe"}, 32'(cnv_rd), 32'd0);
        chk({req, " no sample"}, 32'(saw_valid), 32'd0);
        m_ready = 1'b0;
    endtask

    initial begin
        logic [1:0] md;
        logic       s1;
        void'($urandom(32'd20240611));
        do_reset();
        // R1
        chk("R1 cs_n", 32'(cs_n), 32'd1);
        chk("R1 cnv_rd", 32'(cnv_rd), 32'd0);
        chk("R1 sclk", 32'(sclk), 32'd0);
        chk("R1 m_valid", 32'(m_valid), 32'd0);
        chk("R1 frame_err", 32'(frame_err), 32'd0);
        chk("R1 timeout_err", 32'(timeout_err), 32'd0);

        // directed: full-scale codes and tag patterns
        do_frame(2'b00, 1'b1, {2'b00, 16'h8000, 2'b00}, {2'b00, 16'h7FFF, 2'b00});      // R6 R5
        do_frame(2'b01, 1'b0, {2'b01, 16'h0000, 2'b00}, {2'b11, 16'hFFFF, 2'b11});      // R7, lane B ignored (R11)
        do_frame(2'b10, 1'b0, {2'b10, 16'h0001, 2'b00}, {2'b10, 16'hFFFE, 2'b00});      // R8
        do_frame(2'b11, 1'b1, {2'b01, 16'h7FFE, 2'b00}, {2'b00, 16'h1234, 2'b00});      // R9
        do_frame(2'b11, 1'b0, {2'b10, 16'h8001, 2'b00}, {2'b00, 16'h0000, 2'b00});      // R9

        // random frames
        for (int n = 0; n < 48; n++) begin
            md = 2'($urandom);
            s1 = 1'($urandom);
            do_frame(md, 1'($urandom), rand_frame(md, 1'b0, s1), rand_frame(md, 1'b1, s1));
        end

        // R11: trailing error on a used lane, sample still delivered, flag sticks
        do_frame(2'b00, 1'b0, {2'b00, 16'h5A5A, 2'b00}, {2'b00, 16'hA5A5, 2'b01});
        do_frame(2'b10, 1'b1, {2'b10, 16'h0F0F, 2'b00}, {2'b10, 16'hF0F0, 2'b00});
        do_reset();
        do_frame(2'b11, 1'b0, {2'b11, 16'h3333, 2'b10}, {2'b00, 16'h0000, 2'b00});

        // R12: busy never rises
        do_reset();
        do_timeout(1, "R12");
        // R13: busy stuck high after the frame
        do_reset();
        do_timeout(2, "R13");
        // recovery after reset
        do_reset();
        chk("R1 timeout_err cleared", 32'(timeout_err), 32'd0);
        do_frame(2'b00, 1'b1, {2'b00, 16'hC001, 2'b00}, {2'b00, 16'h3FFE, 2'b00});

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule